// File: doc/BRIEF.md
# Two-wire serial flash responder

This block is the device-side control logic of a small sector-organised serial flash that talks over two wires. One wire is a serial clock driven by the host. The other is a bidirectional data line, which this block brings out as a data input, a data output and an output enable. The serial clock is sampled in the block's own system clock domain. Every instruction bit is taken on a rising edge of the serial clock, most significant bit first. An instruction is an 8-bit opcode. For a read or a write, a 16-bit sector address follows it, and then the sector data moves one bit per rising edge.

A sequence has no explicit end marker. The host ends it by holding the serial clock low for a long interval. That interval resets the control logic to standby, and it also commits a pending sector write. The first rising edge after standby only wakes the device, and the opcode begins on the next edge. Holding the clock high pauses a sequence for as long as the host likes.

Writes always cover a whole sector. Bytes the host never sent are filled with a fixed pattern while a busy timer runs, and a 16-bit status read reports busy or ready. One fixed sector address holds read-only identification data.

Top module: `serflash_resp`

## Requirements
- R1: Bits are taken only on rising edges of `sck`, MSB first, and changes of `sdi` while `sck` is high have no effect. Opcodes are read 03h, write 02h and status 05h. Any other opcode leaves `sdo_oe` low for the rest of the sequence.
- R2: After the last address bit of a read, `sdo_oe` is 1 and `sdo` presents bit 7 of sector byte 0. Each rising edge advances one bit, MSB first. Bytes come in offset order and wrap from offset SECT_BYTES-1 back to 0.
- R3: After `rst_n`, byte 0 of every data sector reads C9h, every other byte reads FFh, and `sdo_oe` is 0.
- R4: Written bytes land at offsets 0, 1, 2 and onward of the addressed sector when the sequence ends. Offsets that were not written take FILL_BYTE (default 5Ah). Bytes beyond SECT_BYTES and a trailing partial byte are ignored.
- R5: `sck` held low for T_RESET system clocks aborts any sequence and enters standby. The next rising edge only wakes the device, and the following edge carries the opcode MSB.
- R6: Holding `sck` high for any number of cycles, including more than T_RESET, pauses a sequence without losing its state.
- R7: Sector address 5000h reads C9h at offset 0, DEV_ID at offset 1, N_SECT at offset 2 and FFh elsewhere. A write to it changes nothing and starts no busy period.
- R8: A status read returns 16 bits after its opcode: 6666h while busy and 9999h otherwise. Busy lasts T_WRITE system clocks from the end of an accepted write.
- R9: While busy, read and write opcodes are rejected. `sdo_oe` stays 0 and the array is not changed.
- R10: During a status read, `sdo_oe` stays 0 until T_RP system clocks have passed since the wake edge of that sequence.
- R11: A sector address that is neither a data sector nor 5000h reads as FFh bytes, and a write to it is ignored without a busy period.
- R12: `sdo_oe` is 0 during opcode, address and write-data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low power-on reset; restores factory contents |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Data line as seen by the device |
| sdo | output | 1 | Data the device drives onto the line |
| sdo_oe | output | 1 | Enable for the device's driver on the data line |

## Verification
The hardest situation to reach is a read or write that arrives while a write commit is still busy. A write is only committed by the clock-low interval that ends its sequence, so the host has to start the next sequences inside the busy window. The bench sets T_WRITE long enough to fit a status read, a rejected read and a rejected write to a second sector inside that window. It then waits for ready and reads both sectors back, which shows that the fill completed and that the rejected write left no trace.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   localparam logic [7:0]  OPC_READ   = 8'h03;
   localparam logic [7:0]  OPC_WRITE  = 8'h02;
   localparam logic [7:0]  OPC_STAT   = 8'h05;
   localparam logic [15:0] STAT_BUSY  = 16'h6666;
   localparam logic [15:0] STAT_READY = 16'h9999;
   localparam logic [7:0]  TAG_BYTE   = 8'hC9;

   typedef enum logic [1:0] {TGT_NONE, TGT_DATA, TGT_INFO} tgt_t;

   typedef enum logic [2:0] {
      ST_SLEEP, ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_STAT, ST_IGNORE
   } seq_state_t;
endpackage

// File: rtl/sfr_link_mon.sv
module sfr_link_mon #(
   parameter int T_RESET = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   output logic rise,
   output logic timeout
);
   localparam int CW = $clog2(T_RESET + 1);

   logic          sck_q;
   logic [CW-1:0] low_cnt;

   generate
      if (T_RESET < 2) begin : g_bad_reset
         $error("T_RESET must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b1;
         low_cnt <= '0;
      end else begin
         sck_q <= sck;
         if (sck)
            low_cnt <= '0;
         else if (low_cnt != CW'(T_RESET))
            low_cnt <= low_cnt + 1'b1;
      end
   end

   assign rise    = sck & ~sck_q;
   assign timeout = ~sck & (low_cnt == CW'(T_RESET - 1));

   // R5: a long low interval yields exactly one reset event
   a_r5_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);
endmodule

// File: rtl/sfr_write_timer.sv
module sfr_write_timer #(
   parameter int T_WRITE    = 3000,
   parameter int SECT_BYTES = 264,
   localparam int IW = $clog2(SECT_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [IW-1:0] start_idx,
   output logic          busy,
   output logic          fill_we,
   output logic [IW-1:0] fill_idx
);
   localparam int TW = $clog2(T_WRITE + 1);

   logic [TW-1:0] busy_cnt;
   logic [IW-1:0] fill_ptr;

   generate
      if (T_WRITE < SECT_BYTES) begin : g_bad_write
         $error("T_WRITE must cover one fill write per sector byte");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
         fill_ptr <= IW'(SECT_BYTES);
      end else if (start) begin
         busy_cnt <= TW'(T_WRITE);
         fill_ptr <= start_idx;
      end else if (busy_cnt != '0) begin
         busy_cnt <= busy_cnt - 1'b1;
         if (fill_ptr != IW'(SECT_BYTES))
            fill_ptr <= fill_ptr + 1'b1;
      end
   end

   assign busy     = (busy_cnt != '0);
   assign fill_we  = busy && (fill_ptr != IW'(SECT_BYTES));
   assign fill_idx = fill_ptr;

   // R4: every unwritten byte is filled before ready is reported
   a_r4_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (fill_ptr == IW'(SECT_BYTES)));
endmodule

// File: rtl/sfr_sector_store.sv
module sfr_sector_store import sfr_pkg::*; #(
   parameter int         N_SECT     = 2,
   parameter int         SECT_BYTES = 264,
   parameter bit         HAS_INFO   = 1'b1,
   parameter logic [7:0] DEV_ID     = 8'h3A,
   localparam int SW = (N_SECT > 1) ? $clog2(N_SECT) : 1,
   localparam int IW = $clog2(SECT_BYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [SW-1:0] w_sec,
   input  logic [IW-1:0] w_idx,
   input  logic [7:0]    w_data,
   input  tgt_t          r_sel,
   input  logic [SW-1:0] r_sec,
   input  logic [IW-1:0] r_idx,
   output logic [7:0]    r_data
);
   localparam int MEMW = N_SECT * SECT_BYTES;
   localparam int AW   = $clog2(MEMW);

   logic [7:0]    mem [MEMW];
   logic [AW-1:0] waddr, raddr;
   logic [7:0]    info_byte;

   assign waddr = AW'(w_sec) * AW'(SECT_BYTES) + AW'(w_idx);
   assign raddr = AW'(r_sec) * AW'(SECT_BYTES) + AW'(r_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEMW; i++)
            mem[i] <= ((i % SECT_BYTES) == 0) ? TAG_BYTE : 8'hFF;
      end else if (we) begin
         mem[waddr] <= w_data;
      end
   end

   generate
      if (HAS_INFO) begin : g_info
         always_comb begin
            case (r_idx)
               IW'(0):  info_byte = TAG_BYTE;
               IW'(1):  info_byte = DEV_ID;
               IW'(2):  info_byte = 8'(N_SECT);
               default: info_byte = 8'hFF;
            endcase
         end
      end else begin : g_no_info
         assign info_byte = 8'hFF;
      end
   endgenerate

   always_comb begin
      case (r_sel)
         TGT_DATA: r_data = mem[raddr];
         TGT_INFO: r_data = info_byte;
         default:  r_data = 8'hFF;
      endcase
   end

   // R4: a write never lands past the end of its sector
   a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (w_idx < IW'(SECT_BYTES)));
endmodule

// File: rtl/serflash_resp.sv
module serflash_resp import sfr_pkg::*; #(
   parameter int          N_SECT     = 2,
   parameter int          SECT_BYTES = 264,
   parameter bit          HAS_INFO   = 1'b1,
   parameter logic [15:0] INFO_SECT  = 16'h5000,
   parameter logic [7:0]  DEV_ID     = 8'h3A,
   parameter logic [7:0]  FILL_BYTE  = 8'h5A,
   parameter int          T_RESET    = 64,
   parameter int          T_WRITE    = 3000,
   parameter int          T_RP       = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic sdi,
   output logic sdo,
   output logic sdo_oe
);
   localparam int SW  = (N_SECT > 1) ? $clog2(N_SECT) : 1;
   localparam int IW  = $clog2(SECT_BYTES + 1);
   localparam int RPW = $clog2(T_RP + 1);

   generate
      if (N_SECT < 1 || N_SECT > 255) begin : g_bad_nsect
         $error("N_SECT must be between 1 and 255");
      end
      if (SECT_BYTES < 4) begin : g_bad_sect
         $error("SECT_BYTES must be at least 4");
      end
   endgenerate

   seq_state_t     state;
   tgt_t           tgt;
   logic [3:0]     cnt;
   logic [15:0]    sh, nxt_sh, stat_word;
   logic           op_read;
   logic [SW-1:0]  sec;
   logic [IW-1:0]  idx;
   logic [RPW-1:0] rp_cnt;
   logic           rise, timeout, busy, fill_we, data_we, store_we, wr_start;
   logic [IW-1:0]  fill_idx, store_idx;
   logic [7:0]     store_data, rd_byte;

   sfr_link_mon #(.T_RESET(T_RESET)) u_mon (
      .clk(clk), .rst_n(rst_n), .sck(sck), .rise(rise), .timeout(timeout));

   assign wr_start = timeout && (state == ST_WDATA) && (tgt == TGT_DATA);

   sfr_write_timer #(.T_WRITE(T_WRITE), .SECT_BYTES(SECT_BYTES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(wr_start), .start_idx(idx),
      .busy(busy), .fill_we(fill_we), .fill_idx(fill_idx));

   assign nxt_sh     = {sh[14:0], sdi};
   assign data_we    = rise && (state == ST_WDATA) && (cnt == 4'd7) &&
                       (tgt == TGT_DATA) && (idx != IW'(SECT_BYTES));
   assign store_we   = fill_we | data_we;
   assign store_idx  = fill_we ? fill_idx : idx;
   assign store_data = fill_we ? FILL_BYTE : nxt_sh[7:0];

   sfr_sector_store #(.N_SECT(N_SECT), .SECT_BYTES(SECT_BYTES),
                      .HAS_INFO(HAS_INFO), .DEV_ID(DEV_ID)) u_store (
      .clk(clk), .rst_n(rst_n), .we(store_we), .w_sec(sec),
      .w_idx(store_idx), .w_data(store_data), .r_sel(tgt), .r_sec(sec),
      .r_idx(idx), .r_data(rd_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_SLEEP;
         tgt       <= TGT_NONE;
         cnt       <= '0;
         sh        <= '0;
         stat_word <= STAT_READY;
         op_read   <= 1'b0;
         sec       <= '0;
         idx       <= '0;
         rp_cnt    <= '0;
      end else begin
         if (rise && state == ST_SLEEP)
            rp_cnt <= '0;
         else if (rp_cnt != RPW'(T_RP))
            rp_cnt <= rp_cnt + 1'b1;

         if (timeout) begin
            state <= ST_SLEEP;
         end else if (rise) begin
            case (state)
               ST_SLEEP: begin
                  state <= ST_OPC;
                  cnt   <= '0;
               end
               ST_OPC: begin
                  sh  <= nxt_sh;
                  cnt <= cnt + 1'b1;
                  if (cnt == 4'd7) begin
                     cnt <= '0;
                     if (nxt_sh[7:0] == OPC_STAT) begin
                        state     <= ST_STAT;
                        stat_word <= busy ? STAT_BUSY : STAT_READY;
                     end else if (!busy && (nxt_sh[7:0] == OPC_READ ||
                                            nxt_sh[7:0] == OPC_WRITE)) begin
                        state   <= ST_ADDR;
                        op_read <= (nxt_sh[7:0] == OPC_READ);
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
               end
               ST_ADDR: begin
                  sh  <= nxt_sh;
                  cnt <= cnt + 1'b1;
                  if (cnt == 4'd15) begin
                     idx   <= '0;
                     sec   <= nxt_sh[SW-1:0];
                     state <= op_read ? ST_RDATA : ST_WDATA;
                     if (nxt_sh < 16'(N_SECT))
                        tgt <= TGT_DATA;
                     else if (HAS_INFO && nxt_sh == INFO_SECT)
                        tgt <= TGT_INFO;
                     else
                        tgt <= TGT_NONE;
                  end
               end
               ST_RDATA: begin
                  cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 1'b1;
                  if (cnt == 4'd7)
                     idx <= (idx == IW'(SECT_BYTES - 1)) ? '0 : idx + 1'b1;
               end
               ST_WDATA: begin
                  sh  <= nxt_sh;
                  cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 1'b1;
                  if (cnt == 4'd7 && idx != IW'(SECT_BYTES))
                     idx <= idx + 1'b1;
               end
               ST_STAT: stat_word <= {stat_word[14:0], stat_word[15]};
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      sdo    = 1'b0;
      sdo_oe = 1'b0;
      if (state == ST_RDATA) begin
         sdo    = rd_byte[3'd7 - cnt[2:0]];
         sdo_oe = 1'b1;
      end else if (state == ST_STAT) begin
         sdo    = stat_word[15];
         sdo_oe = (rp_cnt == RPW'(T_RP));
      end
   end

   // R9: the data write port stays idle while a commit is busy
   a_r9_no_write_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !data_we);
   // R7: nothing reaches the array during a write aimed at the info sector
   a_r7_info_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WDATA && tgt == TGT_INFO) |-> !store_we);
   // R6: with no rising edge and no timeout, the sequence state holds
   a_r6_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise && !timeout) |=> $stable(state));
endmodule

// File: tb/sim_serflash_resp.sv
module sim_serflash_resp;
   localparam int          NS    = 2;
   localparam int          SB    = 264;
   localparam int          TR    = 64;
   localparam int          TW    = 3000;
   localparam int          TRP   = 100;
   localparam int          H     = 4;
   localparam logic [7:0]  DEVID = 8'h3A;
   localparam logic [7:0]  FILL  = 8'h5A;
   localparam logic [15:0] INFO  = 16'h5000;

   logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sdi = 1'b0;
   logic sdo, sdo_oe;
   int   cyc = 0, errs = 0, checks = 0, busy_until = 0;
   int   mm [NS][SB];

   serflash_resp #(.N_SECT(NS), .SECT_BYTES(SB), .HAS_INFO(1'b1),
                   .INFO_SECT(INFO), .DEV_ID(DEVID), .FILL_BYTE(FILL),
                   .T_RESET(TR), .T_WRITE(TW), .T_RP(TRP)) u0 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

   always #5 clk = ~clk;
   always @(posedge clk) cyc++;

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] model_byte(logic [15:0] a, int i);
      if (a < 16'(NS)) return 8'(mm[a][i]);
      if (a == INFO) return (i == 0) ? 8'hC9 : (i == 1) ? DEVID :
                            (i == 2) ? 8'(NS) : 8'hFF;
      return 8'hFF;
   endfunction

   // one serial bit: sample device output at end of low phase, then rise;
   // sdi is flipped while sck is high (must be ignored, R1)
   task automatic bit_cyc(input logic d, output logic q, output logic oe);
      sck = 1'b0; sdi = d;
      repeat (H) @(negedge clk);
      q = sdo; oe = sdo_oe;
      sck = 1'b1;
      @(negedge clk);
      sdi = ~d;
      repeat (H - 1) @(negedge clk);
   endtask

   task automatic send_bits(logic [31:0] v, int n, string tag);
      logic q, oe;
      for (int i = n - 1; i >= 0; i--) begin
         bit_cyc(v[i], q, oe);
         chk(tag, 32'(oe), 0);
      end
   endtask

   task automatic seq_reset();
      sck = 1'b0;
      repeat (TR + 8) @(negedge clk);
      sck = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   task automatic read_op(logic [15:0] a, int nbytes, int pause, string tag);
      logic q, oe;
      seq_reset();
      send_bits(32'h03, 8, "R12 opcode");
      send_bits(32'(a[15:8]), 8, "R12 addr");
      if (pause > 0) repeat (pause) @(negedge clk);
      send_bits(32'(a[7:0]), 8, "R12 addr");
      for (int k = 0; k < nbytes * 8; k++) begin
         bit_cyc(1'b0, q, oe);
         chk("R2 oe during read", 32'(oe), 1);
         chk(tag, 32'(q), 32'(model_byte(a, (k / 8) % SB)[7 - (k % 8)]));
      end
   endtask

   task automatic status_op(logic [15:0] exp, string tag);
      logic q, oe;
      seq_reset();
      send_bits(32'h05, 8, "R12 opcode");
      repeat (TRP) @(negedge clk);
      for (int k = 15; k >= 0; k--) begin
         bit_cyc(1'b0, q, oe);
         chk("R10 oe after delay", 32'(oe), 1);
         chk(tag, 32'(q), 32'(exp[k]));
      end
   endtask

   task automatic write_op(logic [15:0] a, int n, int base, int step,
                           int extra, bit accept);
      seq_reset();
      send_bits(32'h02, 8, "R12 opcode");
      send_bits(32'(a), 16, "R12 addr");
      for (int i = 0; i < n; i++)
         send_bits(32'((base + i * step) & 8'hFF), 8, "R12 wdata");
      if (extra > 0) send_bits(32'h1, extra, "R12 partial");
      sck = 1'b0;
      repeat (TR + 8) @(negedge clk);
      if (accept && a < 16'(NS)) begin
         for (int i = 0; i < SB; i++)
            mm[a][i] = (i < n) ? ((base + i * step) & 8'hFF) : int'(FILL);
         busy_until = cyc + TW;
      end
   endtask

   task automatic wait_ready();
      while (cyc < busy_until + 20) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic q, oe;
      for (int s = 0; s < NS; s++)
         for (int i = 0; i < SB; i++) mm[s][i] = (i == 0) ? 8'hC9 : 8'hFF;
      repeat (5) @(negedge clk);
      chk("R3 oe in reset", 32'(sdo_oe), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R3 oe after reset", 32'(sdo_oe), 0);

      read_op(16'h0000, 8, 0, "R3 factory sector 0");
      read_op(16'h0001, 4, 200, "R6 pause inside address");
      read_op(INFO, 6, 0, "R7 info sector read");
      read_op(16'h0007, 3, 0, "R11 unmapped read");
      status_op(16'h9999, "R8 idle status");

      // R10: first status bit comes too early after the wake edge
      seq_reset();
      send_bits(32'h05, 8, "R12 opcode");
      bit_cyc(1'b0, q, oe);
      chk("R10 oe before delay", 32'(oe), 0);

      // R1: unknown opcode keeps the line released
      seq_reset();
      send_bits(32'hAA, 8, "R12 opcode");
      send_bits(32'h0, 24, "R1 unknown opcode");

      // R5: abort mid-address, next sequence starts clean
      seq_reset();
      send_bits(32'h03, 8, "R12 opcode");
      send_bits(32'h00, 8, "R12 addr");
      status_op(16'h9999, "R5 status after abort");

      // R4: partial write with a trailing partial byte
      write_op(16'h0001, 10, 3, 7, 3, 1'b1);
      status_op(16'h6666, "R8 busy status");
      // R9: read rejected while busy
      seq_reset();
      send_bits(32'h03, 8, "R12 opcode");
      send_bits(32'h0000, 16, "R12 addr");
      send_bits(32'h0, 16, "R9 read rejected while busy");
      write_op(16'h0000, 2, 8'h11, 1, 0, 1'b0);
      wait_ready();
      status_op(16'h9999, "R8 ready status");
      read_op(16'h0001, SB + 2, 0, "R4 partial write and fill");
      read_op(16'h0000, 4, 0, "R9 sector 0 untouched");

      // R7 / R11: writes to info and unmapped sectors do nothing
      write_op(INFO, 3, 8'h20, 1, 0, 1'b0);
      status_op(16'h9999, "R7 no busy after info write");
      read_op(INFO, 4, 0, "R7 info unchanged");
      write_op(16'h0009, 2, 8'h40, 1, 0, 1'b0);
      status_op(16'h9999, "R11 no busy after unmapped write");

      // R4: over-long write, extra bytes dropped
      write_op(16'h0000, SB + 2, 8'h81, 3, 0, 1'b1);
      wait_ready();
      read_op(16'h0000, SB + 2, 0, "R4 full write with overflow");

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule